// File: doc/BRIEF.md
# Legacy Interrupt Aggregator with Write-Enable Mask

This block gathers eight level-sensitive interrupt sources into one status word and drives one interrupt line toward the CPU. The low four sources are the four legacy INTx lines received in root-complex role. The high four are transmit-side sources used in endpoint role. A role input picks which half of the status word counts. The bits of the other half read as zero and never reach the output.

Each source has its own mask bit. Software updates the mask with a single write. The upper half of the write word holds per-bit enables: bit n+16 allows bit n to change. Bits whose enable is clear keep their value. One mask bit can therefore be changed without a read-modify-write and without a lock shared between drivers.

The CPU reaches the block through a plain 32-bit register bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is registered and appears one cycle after the `bus_rd` strobe. The interrupt inputs, the role input and the bus are plain control pins with no back-pressure. The block always accepts a write and always answers a read in the next cycle.

Top module: `intx_aggregator`

## Requirements
- R1: After reset every mask bit is 1 and every status bit is 0. A mask read returns 0x000000FF and `irq_out` is 0.
- R2: A read strobe at byte offset 0x008 returns the status word on `bus_rdata` in the next cycle. Status bit n holds the level that its source input had at the previous clock edge. Source bits 3:0 are `intx_in[3:0]` (INTA to INTD) and bits 7:4 are `tx_irq_in[3:0]`.
- R3: With `ep_role`=0 (root complex), status bits 7:4 read as 0. With `ep_role`=1 (endpoint), status bits 3:0 read as 0. The role is sampled at each clock edge.
- R4: A write to byte offset 0x01C updates mask bit n (n = 0..7) only when `bus_wdata[n+16]` is 1. Mask bits whose enable bit is 0 keep their value.
- R5: An enabled write of 1 to a mask bit masks that source. An enabled write of 0 unmasks it.
- R6: `irq_out` is 1 exactly when some status bit of the active role is 1 and its mask bit is 0. It reflects source, mask and role changes one cycle after they occur.
- R7: Writes to the status offset or to any offset other than 0x01C leave the mask and the status unchanged.
- R8: A mask read returns the mask in bits 7:0 and zeros in bits 31:8. A read of any offset other than 0x008 or 0x01C returns 0.
- R9: Unmasking one INTx line never lets another INTx line that is still masked drive `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_role | input | 1 | 0 = root-complex role, 1 = endpoint role |
| intx_in | input | 4 | Legacy INTx levels, INTA in bit 0 |
| tx_irq_in | input | 4 | Transmit-side interrupt levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data: enables in 23:16, values in 7:0 |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| irq_out | output | 1 | Combined level interrupt toward the CPU |

## Verification
Every result of this block is due exactly one clock edge after its cause. A source level, a role change or a mask write shows on `irq_out` after one edge, and read data appears one edge after the strobe. The bench drives each stimulus on the falling edge and lets one rising edge pass. It then compares on the next falling edge against a model that it updated at that same rising edge. Read data is predicted from the model state before the edge, because the design captures its reply from the registers it held when the strobe was sampled.

// File: rtl/intx_agg_pkg.sv
package intx_agg_pkg;
  localparam int unsigned SRC_PER_ROLE = 4;
  localparam int unsigned SRC_TOTAL    = 2 * SRC_PER_ROLE;
  localparam int unsigned BUS_W        = 32;
  localparam int unsigned ADDR_W       = 12;
  localparam int unsigned WEN_SHIFT    = 16;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h01C;

  typedef enum logic {ROLE_RC = 1'b0, ROLE_EP = 1'b1} role_e;

  function automatic logic [SRC_TOTAL-1:0] role_sel(input role_e r);
    return (r == ROLE_EP) ? {{SRC_PER_ROLE{1'b1}}, {SRC_PER_ROLE{1'b0}}}
                          : {{SRC_PER_ROLE{1'b0}}, {SRC_PER_ROLE{1'b1}}};
  endfunction
endpackage

// File: rtl/intx_src_capture.sv
module intx_src_capture
  import intx_agg_pkg::*;
#(
  parameter int unsigned N = SRC_PER_ROLE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           role_in,
  input  logic [N-1:0]   rx_lvl,
  input  logic [N-1:0]   tx_lvl,
  output logic [2*N-1:0] sts_q,
  output role_e          role_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q  <= '0;
      role_q <= ROLE_RC;
    end else begin
      sts_q  <= {tx_lvl, rx_lvl};
      role_q <= role_e'(role_in);
    end
  end
endmodule

// File: rtl/intx_wen_mask.sv
module intx_wen_mask
  import intx_agg_pkg::*;
#(
  parameter int unsigned N     = SRC_TOTAL,
  parameter int unsigned SHIFT = WEN_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [BUS_W-1:0] wdata,
  output logic [N-1:0]     mask_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[i] <= 1'b1;
      end else if (wr_hit && wdata[i+SHIFT]) begin
        mask_q[i] <= wdata[i];
      end
    end
  end
endmodule

// File: rtl/intx_combine.sv
module intx_combine
  import intx_agg_pkg::*;
#(
  parameter int unsigned N = SRC_TOTAL
) (
  input  logic [N-1:0] sts,
  input  logic [N-1:0] mask,
  input  role_e        role,
  output logic [N-1:0] sts_vis,
  output logic         irq
);
  always_comb begin
    sts_vis = sts & role_sel(role);
    irq     = |(sts_vis & ~mask);
  end
endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator
  import intx_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_role,
  input  logic [3:0]        intx_in,
  input  logic [3:0]        tx_irq_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  logic [SRC_TOTAL-1:0] sts_q;
  logic [SRC_TOTAL-1:0] sts_vis;
  logic [SRC_TOTAL-1:0] mask_q;
  role_e                role_q;
  logic                 mask_wr;
  logic [BUS_W-1:0]     rd_next;

  assign mask_wr = bus_wr && (bus_addr == OFS_MASK);

  intx_src_capture #(.N(SRC_PER_ROLE)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .role_in (ep_role),
    .rx_lvl  (intx_in),
    .tx_lvl  (tx_irq_in),
    .sts_q   (sts_q),
    .role_q  (role_q)
  );

  intx_wen_mask #(.N(SRC_TOTAL), .SHIFT(WEN_SHIFT)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (mask_wr),
    .wdata  (bus_wdata),
    .mask_q (mask_q)
  );

  intx_combine #(.N(SRC_TOTAL)) u_comb (
    .sts     (sts_q),
    .mask    (mask_q),
    .role    (role_q),
    .sts_vis (sts_vis),
    .irq     (irq_out)
  );

  always_comb begin
    rd_next = '0;
    if (bus_addr == OFS_STATUS)    rd_next[SRC_TOTAL-1:0] = sts_vis;
    else if (bus_addr == OFS_MASK) rd_next[SRC_TOTAL-1:0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/intx_aggregator_chk.sv
module intx_aggregator_chk
  import intx_agg_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ep_role,
  input logic [3:0]           intx_in,
  input logic [3:0]           tx_irq_in,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [11:0]          bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 irq_out,
  input logic [SRC_TOTAL-1:0] mask_q
);
  logic live_q;
  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  p_reset_mask_r1: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '1 && !irq_out && bus_rdata == '0));

  p_wen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MASK) |=>
      (((mask_q ^ $past(mask_q)) & ~$past(bus_wdata[WEN_SHIFT+SRC_TOTAL-1:WEN_SHIFT])) == '0));

  p_wen_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MASK) |=>
      (((mask_q ^ $past(bus_wdata[SRC_TOTAL-1:0])) & $past(bus_wdata[WEN_SHIFT+SRC_TOTAL-1:WEN_SHIFT])) == '0));

  p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !(bus_wr && bus_addr == OFS_MASK)) |=> $stable(mask_q));

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (irq_out == |({$past(tx_irq_in), $past(intx_in)} & ~mask_q
                             & role_sel(role_e'($past(ep_role))))));

  p_mask_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_MASK) |=> (bus_rdata[31:SRC_TOTAL] == '0));
endmodule

bind intx_aggregator intx_aggregator_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ep_role   (ep_role),
  .intx_in   (intx_in),
  .tx_irq_in (tx_irq_in),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .mask_q    (mask_q)
);

// File: tb/tb_intx_aggregator.sv
module tb_intx_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ep_role = 1'b0;
  logic [3:0]  intx_in = '0;
  logic [3:0]  tx_irq_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  // bench model
  logic [7:0] m_sts = '0;
  logic [7:0] m_mask = 8'hFF;
  logic       m_role = 1'b0;

  always #5 clk = ~clk;

  intx_aggregator dut (
    .clk(clk), .rst_n(rst_n), .ep_role(ep_role), .intx_in(intx_in),
    .tx_irq_in(tx_irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] vis(input logic [7:0] s, input logic r);
    return r ? (s & 8'hF0) : (s & 8'h0F);
  endfunction

  function automatic logic exp_irq();
    return |(vis(m_sts, m_role) & ~m_mask);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a == 12'h008) return {24'h0, vis(m_sts, m_role)};
    if (a == 12'h01C) return {24'h0, m_mask};
    return 32'h0;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one clock: bus strobes already driven; model tracks the edge, check on negedge
  task automatic cycle(input string tag);
    logic        was_rd = bus_rd;
    logic [31:0] erd = exp_read(bus_addr);
    @(posedge clk);
    if (bus_wr && bus_addr == 12'h01C)
      m_mask = (m_mask & ~bus_wdata[23:16]) | (bus_wdata[7:0] & bus_wdata[23:16]);
    m_sts  = {tx_irq_in, intx_in};
    m_role = ep_role;
    @(negedge clk);
    check(irq_out == exp_irq(), {tag, " R6 irq"}, {31'h0, irq_out}, {31'h0, exp_irq()});
    if (was_rd) check(bus_rdata == erd, {tag, " read"}, bus_rdata, erd);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cycle(tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    cycle(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(irq_out == 1'b0, "R1 irq after reset", {31'h0, irq_out}, 32'h0);
    rd(12'h01C, "R1 R8 mask reset");
    rd(12'h008, "R1 status reset");

    // R9: all INTx active, only INTA unmasked
    intx_in = 4'hF;
    cycle("R2 capture");
    check(irq_out == 1'b0, "R1 all masked", {31'h0, irq_out}, 32'h0);
    wr(12'h01C, 32'h0001_0000, "R5 unmask INTA");
    check(irq_out == 1'b1, "R5 INTA unmasked", {31'h0, irq_out}, 32'h1);
    intx_in = 4'hE;
    cycle("R9 INTA drop");
    check(irq_out == 1'b0, "R9 masked lines stay out", {31'h0, irq_out}, 32'h0);
    rd(12'h008, "R2 status 0xE");
    // R4: enable only bit2, data bits all zero but INTA data 1 without enable
    wr(12'h01C, 32'h0004_0001, "R4 partial write");
    rd(12'h01C, "R4 mask after partial");
    check(irq_out == 1'b1, "R4 INTC now live", {31'h0, irq_out}, 32'h1);
    // R7: status offset write and stray offset write do nothing
    wr(12'h008, 32'h00FF_0000, "R7 status write");
    wr(12'h040, 32'h00FF_0000, "R7 stray write");
    rd(12'h01C, "R7 mask unchanged");
    rd(12'h040, "R8 stray read");
    // R3: endpoint role
    tx_irq_in = 4'h3; ep_role = 1'b1;
    cycle("R3 to EP");
    check(irq_out == 1'b0, "R3 EP tx masked, rx hidden", {31'h0, irq_out}, 32'h0);
    rd(12'h008, "R3 EP status");
    wr(12'h01C, 32'h0010_0000, "R5 unmask tx0");
    check(irq_out == 1'b1, "R3 tx0 live", {31'h0, irq_out}, 32'h1);
    ep_role = 1'b0;
    cycle("R3 back to RC");
    rd(12'h008, "R3 RC status");

    // random mix
    for (int i = 0; i < 400; i++) begin
      intx_in   = 4'($urandom);
      tx_irq_in = 4'($urandom);
      if ($urandom % 8 == 0) ep_role = ~ep_role;
      case ($urandom % 4)
        0: wr(12'h01C, $urandom & 32'h00FF_00FF, "R4 R5 rand write");
        1: rd(($urandom % 2) ? 12'h008 : 12'h01C, "R2 R8 rand read");
        2: wr(12'h008, $urandom, "R7 rand status write");
        default: cycle("R6 rand idle");
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule